// File: doc/BRIEF.md
# Status-Decoded Bus Command Controller

This block turns a 3-bit processor status code into the command strobes and transceiver controls for a single bus cycle on a multiplexed address/data bus. When the status code moves away from the idle (passive) value, the controller starts a cycle. In the first clock of that cycle it pulses an address-latch strobe. It also captures the 20-bit address, made of the 16 shared lines plus four upper lines, together with the upper-byte enable. The address must be captured in that clock because the same lines carry data and status afterwards.

From the second clock the controller asserts the command that matches the decoded cycle type. It also enables the external data transceiver and holds the transceiver direction steady for the whole cycle. A low ready input stretches the cycle one clock at a time. The final clock releases the command and the enable, and the controller then returns to idle and waits for the status to pass through the passive code again.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The cycle type is taken from the status code at the start edge. Code 000 drives `inta_o`, 001 drives `iord_o`, 010 drives `iowr_o`, 100 and 101 both drive `mrd_o`, and 110 drives `mwr_o`. Code 011 (halt) drives no command.
- R2: A cycle starts only in idle, and only when the status is not 111 while the status sampled on the previous edge was 111. If the status is held at a non-passive code after a cycle ends, no new cycle starts. A halt cycle asserts no command and does not assert `den_o`.
- R3: `ale_o` is high for exactly one clock, the first clock after the start edge, and is low at all other times.
- R4: On the edge that ends the strobe clock, `addr_o` captures {`ahi_i`,`ad_i`} (upper lines as bits 19:16) and `bhe_o` captures `bhe_i`. Both then hold until the next strobe clock ends.
- R5: If ready stays high, the command and `den_o` are high for exactly two clocks, starting the clock after the strobe. Both are low in the fourth (last) clock of the cycle.
- R6: `ready_i` is sampled at the end of the second clock and of each wait clock. Each sample that finds it low adds one clock during which the command and `den_o` stay high.
- R7: `dtr_o` is high from the first through the last clock of a write cycle (codes 010 and 110). It is low in read, acknowledge and halt cycles and in idle. It never changes while `den_o` is high.
- R8: A synchronous active-high `rst` makes all commands, `ale_o` and `den_o` low on the following clock. It also returns the controller to idle and clears the captured address and byte enable.
- R9: At most one of the five command outputs is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 3 | Processor cycle status code |
| ad_i | input | 16 | Multiplexed address/data lines (address phase sampled) |
| ahi_i | input | 4 | Upper address lines, status after the first clock |
| bhe_i | input | 1 | Upper data byte enable from the processor |
| ready_i | input | 1 | Slave ready, low inserts wait clocks |
| ale_o | output | 1 | Address latch strobe |
| addr_o | output | 20 | Captured cycle address |
| bhe_o | output | 1 | Captured upper byte enable |
| den_o | output | 1 | Transceiver enable |
| dtr_o | output | 1 | Transceiver direction, high for transmit |
| mrd_o | output | 1 | Memory read command (fetch or read) |
| mwr_o | output | 1 | Memory write command |
| iord_o | output | 1 | I/O read command |
| iowr_o | output | 1 | I/O write command |
| inta_o | output | 1 | Interrupt acknowledge strobe |

## Verification
A stuck or skipped phase shows at the ports within a clock. The latch strobe either lasts too long or never falls. The command window also comes out shorter or longer than two clocks plus one clock per low-ready sample, and the bench counts that window clock by clock. A wrongly latched cycle code shows up in the second clock as the wrong command line or a wrong direction level. A faulty start detector shows a few clocks after a cycle ends, when the status is held non-passive and a spurious strobe appears. Address capture errors are visible in every clock from the second clock onward, because the bench drives unrelated values onto the shared lines once the strobe clock ends.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   typedef enum logic [2:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_PASS  = 3'b111
   } stat_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_TW   = 3'd3,
      PH_T3   = 3'd4,
      PH_T4   = 3'd5
   } phase_e;

   typedef struct packed {
      logic mrd;
      logic mwr;
      logic iord;
      logic iowr;
      logic inta;
      logic data;
      logic wr;
   } dec_t;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
   import bcc_pkg::*;
(
   input  stat_e code_i,
   output dec_t  dec_o
);

   always_comb begin
      dec_o = '0;
      unique case (code_i)
         ST_INTA:  begin dec_o.inta = 1'b1; dec_o.data = 1'b1; end
         ST_IORD:  begin dec_o.iord = 1'b1; dec_o.data = 1'b1; end
         ST_IOWR:  begin dec_o.iowr = 1'b1; dec_o.data = 1'b1; dec_o.wr = 1'b1; end
         ST_FETCH,
         ST_MRD:   begin dec_o.mrd  = 1'b1; dec_o.data = 1'b1; end
         ST_MWR:   begin dec_o.mwr  = 1'b1; dec_o.data = 1'b1; dec_o.wr = 1'b1; end
         default:  dec_o = '0;
      endcase
   end

   always_comb begin
      assert_decode_onehot_R9: assert ($onehot0({dec_o.mrd, dec_o.mwr, dec_o.iord,
                                                 dec_o.iowr, dec_o.inta}));
   end

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
   import bcc_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] status_i,
   input  logic              ready_i,
   output phase_e            phase_o,
   output stat_e             code_o
);

   localparam logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}};

   if (CODE_W != 3) begin : g_bad_code_w
      $error("bcc_seq: status code must be 3 bits");
   end

   phase_e phase_q, phase_d;
   stat_e  code_q;
   logic   prev_pass_q;
   logic   start;

   assign start = (phase_q == PH_IDLE) && (status_i != IDLE_CODE) && prev_pass_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (start) phase_d = PH_T1;
         PH_T1:   phase_d = PH_T2;
         PH_T2,
         PH_TW:   phase_d = ready_i ? PH_T3 : PH_TW;
         PH_T3:   phase_d = PH_T4;
         PH_T4:   phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q     <= PH_IDLE;
         code_q      <= ST_PASS;
         prev_pass_q <= 1'b1;
      end else begin
         phase_q     <= phase_d;
         prev_pass_q <= (status_i == IDLE_CODE);
         if (start) code_q <= stat_e'(status_i);
      end
   end

   assign phase_o = phase_q;
   assign code_o  = code_q;

   assert_t1_to_t2_R3: assert property (@(posedge clk) disable iff (rst)
      phase_q == PH_T1 |=> phase_q == PH_T2);
   assert_wait_insert_R6: assert property (@(posedge clk) disable iff (rst)
      ((phase_q == PH_T2) || (phase_q == PH_TW)) && !ready_i |=> phase_q == PH_TW);
   assert_wait_exit_R6: assert property (@(posedge clk) disable iff (rst)
      ((phase_q == PH_T2) || (phase_q == PH_TW)) && ready_i |=> phase_q == PH_T3);
   assert_no_retrigger_R2: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_IDLE) && !prev_pass_q |=> phase_q == PH_IDLE);
   assert_code_held_R1: assert property (@(posedge clk) disable iff (rst)
      (phase_q != PH_IDLE) && (phase_q != PH_T4) |=> $stable(code_q));

endmodule

// File: rtl/bcc_addr_latch.sv
module bcc_addr_latch #(
   parameter int AD_W  = 16,
   parameter int AHI_W = 4,
   localparam int ADDR_W = AD_W + AHI_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_i,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [(AHI_W>0 ? AHI_W : 1)-1:0] ahi_i,
   input  logic              bhe_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              bhe_o
);

   logic [ADDR_W-1:0] addr_in;

   if (AD_W < 8) begin : g_bad_ad_w
      $error("bcc_addr_latch: shared bus must be at least 8 bits");
   end

   if (AHI_W > 0) begin : g_upper
      assign addr_in = {ahi_i, ad_i};
   end else begin : g_flat
      assign addr_in = ad_i;
      logic unused_ahi;
      assign unused_ahi = ^ahi_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_o <= '0;
         bhe_o  <= 1'b0;
      end else if (cap_i) begin
         addr_o <= addr_in;
         bhe_o  <= bhe_i;
      end
   end

   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> $stable(addr_o) && $stable(bhe_o));
   assert_addr_take_R4: assert property (@(posedge clk) disable iff (rst)
      cap_i |=> addr_o == $past(addr_in));

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
   import bcc_pkg::*;
#(
   parameter int AD_W   = 16,
   parameter int AHI_W  = 4,
   parameter int CODE_W = 3,
   localparam int ADDR_W = AD_W + AHI_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] status_i,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [AHI_W-1:0]  ahi_i,
   input  logic              bhe_i,
   input  logic              ready_i,
   output logic              ale_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              bhe_o,
   output logic              den_o,
   output logic              dtr_o,
   output logic              mrd_o,
   output logic              mwr_o,
   output logic              iord_o,
   output logic              iowr_o,
   output logic              inta_o
);

   if (AHI_W < 1) begin : g_bad_ahi_w
      $error("bus_cmd_ctrl: at least one upper address line required");
   end

   phase_e phase;
   stat_e  code;
   dec_t   dec;
   logic   cmd_win;
   logic   in_cycle;

   bcc_seq #(.CODE_W(CODE_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .status_i (status_i),
      .ready_i  (ready_i),
      .phase_o  (phase),
      .code_o   (code)
   );

   bcc_decode u_dec (
      .code_i (code),
      .dec_o  (dec)
   );

   bcc_addr_latch #(.AD_W(AD_W), .AHI_W(AHI_W)) u_lat (
      .clk    (clk),
      .rst    (rst),
      .cap_i  (phase == PH_T1),
      .ad_i   (ad_i),
      .ahi_i  (ahi_i),
      .bhe_i  (bhe_i),
      .addr_o (addr_o),
      .bhe_o  (bhe_o)
   );

   assign cmd_win  = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
   assign in_cycle = (phase != PH_IDLE);

   assign ale_o  = (phase == PH_T1);
   assign den_o  = cmd_win & dec.data;
   assign dtr_o  = in_cycle & dec.wr;
   assign mrd_o  = cmd_win & dec.mrd;
   assign mwr_o  = cmd_win & dec.mwr;
   assign iord_o = cmd_win & dec.iord;
   assign iowr_o = cmd_win & dec.iowr;
   assign inta_o = cmd_win & dec.inta;

   assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mrd_o, mwr_o, iord_o, iowr_o, inta_o}));
   assert_ale_single_R3: assert property (@(posedge clk) disable iff (rst)
      ale_o |=> !ale_o);
   assert_cmd_needs_den_R5: assert property (@(posedge clk) disable iff (rst)
      (mrd_o || mwr_o || iord_o || iowr_o || inta_o) |-> den_o);
   assert_release_last_R5: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_T3) |=> !den_o && !mrd_o && !mwr_o && !iord_o && !iowr_o && !inta_o);
   assert_dir_steady_R7: assert property (@(posedge clk) disable iff (rst)
      den_o |-> $stable(dtr_o));
   assert_reset_quiet_R8: assert property (@(posedge clk)
      rst |=> !ale_o && !den_o && !mrd_o && !mwr_o && !iord_o && !iowr_o && !inta_o);

endmodule

// File: tb/bus_cmd_ctrl_tb.sv
module bus_cmd_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  status_i;
   logic [15:0] ad_i;
   logic [3:0]  ahi_i;
   logic        bhe_i;
   logic        ready_i;
   logic        ale_o, bhe_o, den_o, dtr_o;
   logic        mrd_o, mwr_o, iord_o, iowr_o, inta_o;
   logic [19:0] addr_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   bus_cmd_ctrl u_dut (
      .clk(clk), .rst(rst), .status_i(status_i), .ad_i(ad_i), .ahi_i(ahi_i),
      .bhe_i(bhe_i), .ready_i(ready_i), .ale_o(ale_o), .addr_o(addr_o),
      .bhe_o(bhe_o), .den_o(den_o), .dtr_o(dtr_o), .mrd_o(mrd_o), .mwr_o(mwr_o),
      .iord_o(iord_o), .iowr_o(iowr_o), .inta_o(inta_o)
   );

   function automatic logic [4:0] exp_cmd(input logic [2:0] c);
      case (c)
         3'b000:         return 5'b10000;
         3'b001:         return 5'b00100;
         3'b010:         return 5'b01000;
         3'b100, 3'b101: return 5'b00001;
         3'b110:         return 5'b00010;
         default:        return 5'b00000;
      endcase
   endfunction

   function automatic logic exp_data(input logic [2:0] c);
      return (c != 3'b011) && (c != 3'b111);
   endfunction

   function automatic logic exp_wr(input logic [2:0] c);
      return (c == 3'b010) || (c == 3'b110);
   endfunction

   function automatic logic [4:0] cmd_now();
      return {inta_o, iowr_o, iord_o, mwr_o, mrd_o};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // One bus cycle; hold keeps status non-passive after the start.
   task automatic run_cycle(input logic [2:0] code, input logic [19:0] addr,
                            input logic bhe, input int waits, input bit hold);
      @(negedge clk);
      status_i = code; ad_i = addr[15:0]; ahi_i = addr[19:16]; bhe_i = bhe;
      ready_i = 1'b1;
      @(negedge clk); // first clock: strobe
      chk(ale_o == 1'b1, "R3 strobe in first clock", 32'(ale_o), 32'd1);
      chk(cmd_now() == 5'd0, "R5 no command in first clock", 32'(cmd_now()), 32'd0);
      chk(dtr_o == exp_wr(code), "R7 direction first clock", 32'(dtr_o), 32'(exp_wr(code)));
      if (!hold) status_i = 3'b111;
      @(negedge clk); // second clock
      ad_i = 16'($urandom); ahi_i = 4'($urandom); bhe_i = ~bhe;
      chk(ale_o == 1'b0, "R3 strobe one clock only", 32'(ale_o), 32'd0);
      chk(addr_o == addr, "R4 address captured", 32'(addr_o), 32'(addr));
      chk(bhe_o == bhe, "R4 byte enable captured", 32'(bhe_o), 32'(bhe));
      chk(cmd_now() == exp_cmd(code), "R1 command decode", 32'(cmd_now()), 32'(exp_cmd(code)));
      chk(den_o == exp_data(code), "R5 enable second clock", 32'(den_o), 32'(exp_data(code)));
      chk(dtr_o == exp_wr(code), "R7 direction second clock", 32'(dtr_o), 32'(exp_wr(code)));
      ready_i = (waits == 0);
      for (int i = 0; i < waits; i++) begin
         @(negedge clk);
         chk(cmd_now() == exp_cmd(code), "R6 command held in wait", 32'(cmd_now()),
             32'(exp_cmd(code)));
         chk(den_o == exp_data(code), "R6 enable held in wait", 32'(den_o),
             32'(exp_data(code)));
         ready_i = (i == waits - 1);
      end
      @(negedge clk); // third clock
      ready_i = 1'($urandom);
      chk(cmd_now() == exp_cmd(code), "R5 command third clock", 32'(cmd_now()),
          32'(exp_cmd(code)));
      chk(addr_o == addr, "R4 address held", 32'(addr_o), 32'(addr));
      @(negedge clk); // last clock
      chk(cmd_now() == 5'd0, "R5 command released", 32'(cmd_now()), 32'd0);
      chk(den_o == 1'b0, "R5 enable released", 32'(den_o), 32'd0);
      chk(dtr_o == exp_wr(code), "R7 direction last clock", 32'(dtr_o), 32'(exp_wr(code)));
      @(negedge clk); // idle
      chk(ale_o == 1'b0 && dtr_o == 1'b0, "R2 idle after cycle", {30'd0, ale_o, dtr_o}, 32'd0);
      ready_i = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; status_i = 3'b111; ad_i = '0; ahi_i = '0; bhe_i = 1'b0; ready_i = 1'b1;
      repeat (3) @(negedge clk);
      chk({ale_o, den_o, cmd_now()} == 7'd0, "R8 reset state", 32'({ale_o, den_o, cmd_now()}), 32'd0);
      chk(addr_o == 20'd0, "R8 address cleared", 32'(addr_o), 32'd0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(ale_o == 1'b0, "R2 passive stays idle", 32'(ale_o), 32'd0);

      // every code in order, no waits
      for (int c = 0; c < 7; c++) run_cycle(3'(c), 20'h12345 + 20'(c * 4099), 1'(c), 0, 1'b0);

      // held status must not retrigger
      run_cycle(3'b101, 20'hFEDCB, 1'b1, 2, 1'b1);
      repeat (3) begin
         @(negedge clk);
         chk(ale_o == 1'b0, "R2 no retrigger while held", 32'(ale_o), 32'd0);
      end
      status_i = 3'b111;
      @(negedge clk);

      // halt: no command, no enable
      run_cycle(3'b011, 20'h0F0F0, 1'b0, 1, 1'b0);
      chk(den_o == 1'b0, "R2 halt no enable", 32'(den_o), 32'd0);

      // long wait
      run_cycle(3'b110, 20'hAAAAA, 1'b1, 6, 1'b0);

      // reset mid-cycle
      @(negedge clk);
      status_i = 3'b001; ready_i = 1'b0;
      @(negedge clk);
      status_i = 3'b111;
      @(negedge clk);
      chk(iord_o == 1'b1, "R1 read before reset", 32'(iord_o), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      chk({ale_o, den_o, dtr_o, cmd_now()} == 8'd0, "R8 reset mid-cycle",
          32'({ale_o, den_o, dtr_o, cmd_now()}), 32'd0);
      chk(addr_o == 20'd0, "R8 address cleared mid-cycle", 32'(addr_o), 32'd0);
      rst = 1'b0; ready_i = 1'b1;
      @(negedge clk);
      chk(cmd_now() == 5'd0, "R8 idle after reset", 32'(cmd_now()), 32'd0);

      // random cycles
      for (int n = 0; n < 40; n++) begin
         logic [2:0] c;
         c = 3'($urandom_range(0, 6));
         run_cycle(c, 20'($urandom), 1'($urandom), int'($urandom_range(0, 3)), 1'b0);
         chk($countones(cmd_now()) <= 1, "R9 one command", 32'(cmd_now()), 32'd0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1-path actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule